// File: doc/BRIEF.md
# Low-Power Mode Sequencer for an LPDDR Memory Controller

This block sits between a memory controller's command path and the DRAM pins. It decides nothing about *when* to save power. Instead it takes level requests for self-refresh, power-down, deep power-down and a status-register read. It serves each request once the request's preconditions hold. It then drives clock-enable (CKE) and the special commands that enter and leave each mode. It counts the minimum residency and exit windows. While a window runs or a sequence is in flight, it replaces host commands with NOP.

In normal operation, host commands pass through in the same cycle and `traffic_ok_o` is high. A host command offered while `traffic_ok_o` is low is dropped, and the host retries it later. The block follows which banks hold an open row by watching the ACT, PRE and PRE-all commands it actually forwards. Self-refresh, deep power-down and the status read all need every bank closed and a quiet data bus. After a deep power-down exit, `need_reinit_o` tells the host that only the initialization sequence may run until `init_done_i` is reported.

Command codes on `host_cmd_i` and `cmd_o`: NOP=0, ACT=1, RD=2, WR=3, PRE=4, PRE-all=5, REF=6, MRS=7, BST=8.

Top module: `lpm_ctrl`

## Requirements
- R1: With no window running and no request being served, `cmd_o`/`ba_o` equal `host_cmd_i`/`host_ba_i` in the same cycle, with `traffic_ok_o`=1 and `cke_o`=1.
- R2: A self-refresh request is served only when no bank is open and `data_busy_i`=0. Until then it is held while traffic flows. When served, it emits REF (6) with `cke_o`=0 in that cycle.
- R3: After self-refresh entry in cycle e, `cke_o` stays 0 through at least cycle e+T_RFC-1. The exit (`cke_o`=1 with NOP) occurs in the first cycle at or after e+T_RFC in which the request is low.
- R4: After a self-refresh exit in cycle x, only NOP appears until cycle x+T_XS. That cycle carries the extra REF. `traffic_ok_o` returns at x+T_XS+T_RFC.
- R5: A power-down request is served regardless of open banks, with `cke_o`=0 and NOP. During the power-down, `pd_active_o` is 1 exactly when a bank was open at entry (active rather than precharge power-down).
- R6: Power-down holds `cke_o` low for at least T_CKE cycles. The exit is `cke_o`=1 with NOP in cycle x, and `traffic_ok_o` returns at x+T_XP.
- R7: Deep power-down is entered with BST (8) and `cke_o`=0, only with all banks closed and a quiet data bus. After the exit cycle, `need_reinit_o` is 1 until the cycle after `init_done_i`. Meanwhile host commands are forwarded and low-power requests are ignored.
- R8: A status read emits MRS (7) with `ba_o`=1, only with all banks closed and a quiet bus. Only NOP follows for T_SRR cycles. Then RD (2) with `ba_o`=0 and `srr_ack_o`=1 appears. `traffic_ok_o` returns CL+1 cycles after that RD.
- R9: While `traffic_ok_o` is 0, no host command reaches `cmd_o`.
- R10: Among requests whose conditions hold, deep power-down wins over status read, which wins over self-refresh, which wins over power-down.
- R11: After reset, `cke_o`=1, `traffic_ok_o`=1, and `need_reinit_o`, `pd_active_o` and `srr_ack_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd_i | input | 4 | Host command code |
| host_ba_i | input | BA_W | Host bank address |
| sr_req_i | input | 1 | Self-refresh request (level) |
| pd_req_i | input | 1 | Power-down request (level) |
| dpd_req_i | input | 1 | Deep power-down request (level) |
| srr_req_i | input | 1 | Status-read request, held until acknowledged |
| data_busy_i | input | 1 | Data bus still carrying a burst |
| init_done_i | input | 1 | Initialization sequence finished |
| cke_o | output | 1 | Clock enable to the DRAM |
| cmd_o | output | 4 | Command to the DRAM |
| ba_o | output | BA_W | Bank address to the DRAM |
| traffic_ok_o | output | 1 | Host command forwarded this cycle |
| srr_ack_o | output | 1 | Status-read RD issued this cycle |
| pd_active_o | output | 1 | Current power-down has a row open |
| need_reinit_o | output | 1 | Full re-initialization required |

## Verification
The hardest conditions to reach are a request that is pending while its precondition is false, and a request that is still held when its minimum window ends. In the first case a bank is open or the bus is busy. In the second case the residency must stretch past the minimum. Directed sequences open a bank, raise the request, hold it across several cycles of traffic, and then close the bank so that the entry cycle is known. Random power-down episodes choose hold lengths on both sides of T_CKE over a randomly opened bank set. A bench function computes the expected exit cycle and the active or precharge flavour.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_NOP  = 4'd0;
  localparam logic [CMD_W-1:0] CMD_ACT  = 4'd1;
  localparam logic [CMD_W-1:0] CMD_RD   = 4'd2;
  localparam logic [CMD_W-1:0] CMD_WR   = 4'd3;
  localparam logic [CMD_W-1:0] CMD_PRE  = 4'd4;
  localparam logic [CMD_W-1:0] CMD_PREA = 4'd5;
  localparam logic [CMD_W-1:0] CMD_REF  = 4'd6;
  localparam logic [CMD_W-1:0] CMD_MRS  = 4'd7;
  localparam logic [CMD_W-1:0] CMD_BST  = 4'd8;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SR,
    ST_XS,
    ST_PD,
    ST_DPD,
    ST_INIT,
    ST_SRG
  } lpm_state_e;
endpackage

// File: rtl/lpm_bank_track.sv
module lpm_bank_track
  import lpm_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int BA_W = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd,
  input  logic [BA_W-1:0]  ba,
  output logic             all_idle
);
  logic [NBANK-1:0] open_vec;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    logic set_open;
    logic clr_open;
    logic open_q;

    assign hit      = (ba == BA_W'(b));
    assign set_open = (cmd == CMD_ACT) && hit;
    assign clr_open = (cmd == CMD_PREA) || ((cmd == CMD_PRE) && hit);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
      end else if (set_open || clr_open) begin
        open_q <= set_open;
      end
    end

    assign open_vec[b] = open_q;
  end

  assign all_idle = ~|open_vec;
endmodule

// File: rtl/lpm_timer.sv
module lpm_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load || !zero;

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int CNT_W = 4,
  parameter int T_RFC = 6,
  parameter int T_XS  = 8,
  parameter int T_CKE = 3,
  parameter int T_XP  = 2,
  parameter int T_SRR = 2,
  parameter int T_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] host_cmd,
  input  logic [BA_W-1:0]  host_ba,
  input  logic             sr_req,
  input  logic             pd_req,
  input  logic             dpd_req,
  input  logic             srr_req,
  input  logic             data_busy,
  input  logic             init_done,
  input  logic             all_idle,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             cke,
  output logic [CMD_W-1:0] cmd,
  output logic [BA_W-1:0]  ba,
  output logic             traffic_ok,
  output logic             srr_ack,
  output logic             pd_active,
  output logic             need_reinit
);
  lpm_state_e state_q, state_d;
  logic       pdact_q, pdact_d;
  logic       reinit_q, reinit_d;
  logic       quiet;

  assign quiet = all_idle && !data_busy;

  always_comb begin
    state_d    = state_q;
    pdact_d    = pdact_q;
    reinit_d   = reinit_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    cke        = 1'b1;
    cmd        = CMD_NOP;
    ba         = '0;
    traffic_ok = 1'b0;
    srr_ack    = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (tmr_zero) begin
          if (dpd_req && quiet) begin
            cmd     = CMD_BST;
            cke     = 1'b0;
            state_d = ST_DPD;
          end else if (srr_req && quiet) begin
            cmd      = CMD_MRS;
            ba       = BA_W'(1);
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_SRR - 1);
            state_d  = ST_SRG;
          end else if (sr_req && quiet) begin
            cmd      = CMD_REF;
            cke      = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RFC - 1);
            state_d  = ST_SR;
          end else if (pd_req) begin
            cke      = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_CKE - 1);
            pdact_d  = !all_idle;
            state_d  = ST_PD;
          end else begin
            traffic_ok = 1'b1;
            cmd        = host_cmd;
            ba         = host_ba;
          end
        end
      end
      ST_SR: begin
        cke = 1'b0;
        if (tmr_zero && !sr_req) begin
          cke      = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_XS - 1);
          state_d  = ST_XS;
        end
      end
      ST_XS: begin
        if (tmr_zero) begin
          cmd      = CMD_REF;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_RFC - 1);
          state_d  = ST_RUN;
        end
      end
      ST_PD: begin
        cke = 1'b0;
        if (tmr_zero && !pd_req) begin
          cke      = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_XP - 1);
          pdact_d  = 1'b0;
          state_d  = ST_RUN;
        end
      end
      ST_DPD: begin
        cke = 1'b0;
        if (!dpd_req) begin
          cke      = 1'b1;
          reinit_d = 1'b1;
          state_d  = ST_INIT;
        end
      end
      ST_INIT: begin
        traffic_ok = 1'b1;
        cmd        = host_cmd;
        ba         = host_ba;
        if (init_done) begin
          reinit_d = 1'b0;
          state_d  = ST_RUN;
        end
      end
      ST_SRG: begin
        if (tmr_zero) begin
          cmd      = CMD_RD;
          srr_ack  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_SRC - 1);
          state_d  = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      pdact_q  <= 1'b0;
      reinit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pdact_q  <= pdact_d;
      reinit_q <= reinit_d;
    end
  end

  assign pd_active   = pdact_q;
  assign need_reinit = reinit_q;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int T_RFC = 6,
  parameter int T_XS  = 8,
  parameter int T_CKE = 3,
  parameter int T_XP  = 2,
  parameter int T_SRR = 2,
  parameter int CL    = 3,
  localparam int BA_W  = $clog2(NBANK),
  localparam int T_SRC = CL + 1,
  localparam int TM_A  = (T_RFC > T_XS) ? T_RFC : T_XS,
  localparam int TM_B  = (T_CKE > T_XP) ? T_CKE : T_XP,
  localparam int TM_C  = (T_SRR > T_SRC) ? T_SRR : T_SRC,
  localparam int TM_AB = (TM_A > TM_B) ? TM_A : TM_B,
  localparam int TMAX  = (TM_AB > TM_C) ? TM_AB : TM_C,
  localparam int CNT_W = $clog2(TMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] host_cmd_i,
  input  logic [BA_W-1:0]  host_ba_i,
  input  logic             sr_req_i,
  input  logic             pd_req_i,
  input  logic             dpd_req_i,
  input  logic             srr_req_i,
  input  logic             data_busy_i,
  input  logic             init_done_i,
  output logic             cke_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [BA_W-1:0]  ba_o,
  output logic             traffic_ok_o,
  output logic             srr_ack_o,
  output logic             pd_active_o,
  output logic             need_reinit_o
);
  logic             all_idle;
  logic             tmr_zero;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  lpm_bank_track #(.NBANK(NBANK)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd_o),
    .ba       (ba_o),
    .all_idle (all_idle)
  );

  lpm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  lpm_seq #(
    .BA_W(BA_W), .CNT_W(CNT_W), .T_RFC(T_RFC), .T_XS(T_XS),
    .T_CKE(T_CKE), .T_XP(T_XP), .T_SRR(T_SRR), .T_SRC(T_SRC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_cmd    (host_cmd_i),
    .host_ba     (host_ba_i),
    .sr_req      (sr_req_i),
    .pd_req      (pd_req_i),
    .dpd_req     (dpd_req_i),
    .srr_req     (srr_req_i),
    .data_busy   (data_busy_i),
    .init_done   (init_done_i),
    .all_idle    (all_idle),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .cke         (cke_o),
    .cmd         (cmd_o),
    .ba          (ba_o),
    .traffic_ok  (traffic_ok_o),
    .srr_ack     (srr_ack_o),
    .pd_active   (pd_active_o),
    .need_reinit (need_reinit_o)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int T_RFC = 6,
  parameter int T_XS  = 8,
  parameter int T_CKE = 3,
  parameter int T_XP  = 2,
  parameter int T_SRR = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke_o,
  input logic [CMD_W-1:0] cmd_o,
  input logic [BA_W-1:0]  ba_o,
  input logic             traffic_ok_o,
  input logic             need_reinit_o,
  input logic             init_done_i,
  input logic             all_idle
);
  logic             prev_cke_q;
  logic [CMD_W-1:0] kind_q;
  logic [CMD_W-1:0] gkind_q;
  logic [15:0]      low_cnt_q;
  logic [15:0]      gap_q;
  logic             gap_arm_q;
  logic [15:0]      srr_cnt_q;
  logic             srr_arm_q;
  logic             fall;
  logic             rise;

  assign fall = !cke_o && prev_cke_q;
  assign rise = cke_o && !prev_cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cke_q <= 1'b1;
      kind_q     <= CMD_NOP;
      gkind_q    <= CMD_NOP;
      low_cnt_q  <= '0;
      gap_q      <= '0;
      gap_arm_q  <= 1'b0;
      srr_cnt_q  <= '0;
      srr_arm_q  <= 1'b0;
    end else begin
      prev_cke_q <= cke_o;
      if (fall) begin
        kind_q    <= cmd_o;
        low_cnt_q <= 16'd1;
      end else if (!cke_o && low_cnt_q != 16'hFFFF) begin
        low_cnt_q <= low_cnt_q + 16'd1;
      end
      if (rise) begin
        gkind_q   <= kind_q;
        gap_arm_q <= 1'b1;
        gap_q     <= 16'd1;
      end else if (gap_arm_q) begin
        if (cmd_o != CMD_NOP) gap_arm_q <= 1'b0;
        if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
      end
      if (cmd_o == CMD_MRS && ba_o == BA_W'(1)) begin
        srr_arm_q <= 1'b1;
        srr_cnt_q <= 16'd1;
      end else if (srr_arm_q) begin
        if (cmd_o != CMD_NOP) srr_arm_q <= 1'b0;
        if (srr_cnt_q != 16'hFFFF) srr_cnt_q <= srr_cnt_q + 16'd1;
      end
    end
  end

  assert_sr_entry_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REF && !cke_o) |-> all_idle);

  assert_sr_residency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && kind_q == CMD_REF) |-> (int'(low_cnt_q) >= T_RFC));

  assert_sr_exit_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_arm_q && cmd_o != CMD_NOP && gkind_q == CMD_REF) |-> (int'(gap_q) >= T_XS));

  assert_pd_residency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && kind_q == CMD_NOP) |-> (int'(low_cnt_q) >= T_CKE));

  assert_pd_exit_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_arm_q && cmd_o != CMD_NOP && gkind_q == CMD_NOP) |-> (int'(gap_q) >= T_XP));

  assert_dpd_entry_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_BST && !cke_o) |-> all_idle);

  assert_reinit_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (need_reinit_o && !init_done_i) |=> need_reinit_o);

  assert_srr_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (srr_arm_q && cmd_o != CMD_NOP) |-> (cmd_o == CMD_RD && int'(srr_cnt_q) >= T_SRR));

  assert_no_host_when_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !traffic_ok_o |-> (cmd_o != CMD_ACT && cmd_o != CMD_WR &&
                       cmd_o != CMD_PRE && cmd_o != CMD_PREA));

  assert_quiet_while_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_o && !prev_cke_q) |-> (cmd_o == CMD_NOP));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(
  .BA_W(BA_W), .T_RFC(T_RFC), .T_XS(T_XS), .T_CKE(T_CKE),
  .T_XP(T_XP), .T_SRR(T_SRR)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cke_o         (cke_o),
  .cmd_o         (cmd_o),
  .ba_o          (ba_o),
  .traffic_ok_o  (traffic_ok_o),
  .need_reinit_o (need_reinit_o),
  .init_done_i   (init_done_i),
  .all_idle      (all_idle)
);

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int RFC = 6;
  localparam int XS  = 8;
  localparam int CKE = 3;
  localparam int XP  = 2;
  localparam int SRR = 2;
  localparam int CLAT = 3;
  localparam int SRC = CLAT + 1;

  localparam logic [3:0] NOP = 4'd0, ACT = 4'd1, RD = 4'd2, WR = 4'd3,
                         PRE = 4'd4, PREA = 4'd5, REF = 4'd6, MRS = 4'd7,
                         BST = 4'd8;

  logic       clk;
  logic       rst_n;
  logic [3:0] host_cmd;
  logic [1:0] host_ba;
  logic       sr_req, pd_req, dpd_req, srr_req, data_busy, init_done;
  logic       cke, ok, ack, pdact, reinit;
  logic [3:0] cmd;
  logic [1:0] ba;

  logic r_sr, r_pd, r_dpd, r_srr, r_busy, r_init;
  int   checks;
  int   errors;
  bit   finished;
  bit   bank_open [4];

  lpm_ctrl #(.NBANK(4), .T_RFC(RFC), .T_XS(XS), .T_CKE(CKE), .T_XP(XP),
             .T_SRR(SRR), .CL(CLAT)) u0 (
    .clk(clk), .rst_n(rst_n), .host_cmd_i(host_cmd), .host_ba_i(host_ba),
    .sr_req_i(sr_req), .pd_req_i(pd_req), .dpd_req_i(dpd_req),
    .srr_req_i(srr_req), .data_busy_i(data_busy), .init_done_i(init_done),
    .cke_o(cke), .cmd_o(cmd), .ba_o(ba), .traffic_ok_o(ok),
    .srr_ack_o(ack), .pd_active_o(pdact), .need_reinit_o(reinit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [1:0] b);
    @(negedge clk);
    host_cmd  = c;
    host_ba   = b;
    sr_req    = r_sr;
    pd_req    = r_pd;
    dpd_req   = r_dpd;
    srr_req   = r_srr;
    data_busy = r_busy;
    init_done = r_init;
    #1;
  endtask

  function automatic int exp_pd_len(input int hold);
    return (hold + 1 > CKE) ? hold + 1 : CKE;
  endfunction

  function automatic bit any_open();
    return bank_open[0] || bank_open[1] || bank_open[2] || bank_open[3];
  endfunction

  task automatic model_cmd(input logic [3:0] c, input logic [1:0] b);
    if (c == ACT) bank_open[b] = 1'b1;
    if (c == PRE) bank_open[b] = 1'b0;
    if (c == PREA) for (int i = 0; i < 4; i++) bank_open[i] = 1'b0;
  endtask

  // called after the cycle in which cke returned high from self-refresh
  task automatic sr_exit_tail();
    for (int k = 1; k < XS; k++) begin
      step(ACT, 2'd0);
      chk("R4 nop in exit window", int'(cmd), int'(NOP));
      chk("R9 blocked in exit window", int'(ok), 0);
    end
    step(NOP, 2'd0);
    chk("R4 extra refresh after exit", int'(cmd), int'(REF));
    for (int k = 1; k < RFC; k++) begin
      step(WR, 2'd0);
      chk("R4 refresh window blocks", int'(cmd), int'(NOP));
    end
    step(NOP, 2'd0);
    chk("R4 traffic resumes", int'(ok), 1);
  endtask

  task automatic pd_exit_tail();
    for (int k = 1; k < XP; k++) begin
      step(ACT, 2'd3);
      chk("R6 exit window blocks", int'(ok), 0);
      chk("R9 no forward", int'(cmd), int'(NOP));
    end
    step(NOP, 2'd0);
    chk("R6 traffic resumes", int'(ok), 1);
  endtask

  // called after the MRS cycle
  task automatic srr_tail();
    for (int k = 1; k < SRR; k++) begin
      step(ACT, 2'd1);
      chk("R8 only nop before read", int'(cmd), int'(NOP));
    end
    step(NOP, 2'd0);
    chk("R8 read issued", int'(cmd), int'(RD));
    chk("R8 read bank", int'(ba), 0);
    chk("R8 ack", int'(ack), 1);
    r_srr = 1'b0;
    for (int k = 1; k < SRC; k++) begin
      step(RD, 2'd0);
      chk("R8 read-to-next window", int'(ok), 0);
    end
    step(NOP, 2'd0);
    chk("R8 traffic resumes", int'(ok), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    checks = 0; errors = 0; finished = 1'b0;
    seed = $urandom(32'd20240);
    r_sr = 0; r_pd = 0; r_dpd = 0; r_srr = 0; r_busy = 0; r_init = 0;
    host_cmd = NOP; host_ba = 0; sr_req = 0; pd_req = 0; dpd_req = 0;
    srr_req = 0; data_busy = 0; init_done = 0;
    for (int i = 0; i < 4; i++) bank_open[i] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    step(NOP, 2'd0);
    chk("R11 cke", int'(cke), 1);
    chk("R11 ok", int'(ok), 1);
    chk("R11 reinit", int'(reinit), 0);
    chk("R11 pd_active", int'(pdact), 0);
    chk("R11 ack", int'(ack), 0);

    // R1 forwarding
    step(ACT, 2'd2);
    chk("R1 cmd", int'(cmd), int'(ACT));
    chk("R1 ba", int'(ba), 2);
    chk("R1 ok", int'(ok), 1);

    // R2 held while bank 2 open
    r_sr = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step(RD, 2'd2);
      chk("R2 held cke", int'(cke), 1);
      chk("R1 forward during hold", int'(cmd), int'(RD));
    end
    step(PRE, 2'd2);
    chk("R1 pre forwarded", int'(cmd), int'(PRE));
    step(ACT, 2'd1);
    chk("R2 entry refresh", int'(cmd), int'(REF));
    chk("R2 entry cke", int'(cke), 0);
    chk("R9 entry drops host", int'(ok), 0);
    r_sr = 1'b0;
    for (int k = 1; k < RFC; k++) begin
      step(ACT, 2'd0);
      chk("R3 residency cke", int'(cke), 0);
      chk("R9 nop in self-refresh", int'(cmd), int'(NOP));
    end
    step(NOP, 2'd0);
    chk("R3 exit at minimum", int'(cke), 1);
    chk("R3 exit nop", int'(cmd), int'(NOP));
    sr_exit_tail();

    // R2 busy bus blocks entry; R3 held request stretches residency
    r_busy = 1'b1; r_sr = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(NOP, 2'd0);
      chk("R2 busy holds", int'(cke), 1);
    end
    r_busy = 1'b0;
    step(NOP, 2'd0);
    chk("R2 entry after bus quiet", int'(cmd), int'(REF));
    for (int k = 1; k < RFC + 3; k++) begin
      step(NOP, 2'd0);
      chk("R3 stays while requested", int'(cke), 0);
    end
    r_sr = 1'b0;
    step(NOP, 2'd0);
    chk("R3 exit after release", int'(cke), 1);
    sr_exit_tail();

    // R5 active power-down
    step(ACT, 2'd1);
    model_cmd(ACT, 2'd1);
    r_pd = 1'b1;
    step(ACT, 2'd0);
    chk("R5 entry cke", int'(cke), 0);
    chk("R5 entry nop", int'(cmd), int'(NOP));
    r_pd = 1'b0;
    for (int k = 1; k < CKE; k++) begin
      step(NOP, 2'd0);
      chk("R6 residency", int'(cke), 0);
      chk("R5 active flavour", int'(pdact), 1);
    end
    step(NOP, 2'd0);
    chk("R6 exit", int'(cke), 1);
    pd_exit_tail();

    // random traffic and power-down episodes (R1, R5, R6)
    for (int ep = 0; ep < 12; ep++) begin
      for (int t = 0; t < 20; t++) begin
        logic [3:0] c;
        logic [1:0] b;
        int sel;
        sel = int'($urandom_range(0, 9));
        b = 2'($urandom_range(0, 3));
        case (sel)
          0, 1: c = ACT;
          2: c = RD;
          3: c = WR;
          4, 5: c = PRE;
          6: c = PREA;
          default: c = NOP;
        endcase
        step(c, b);
        chk("R1 random cmd", int'(cmd), int'(c));
        chk("R1 random ba", int'(ba), int'(b));
        model_cmd(c, b);
      end
      begin
        int hold;
        int got;
        bit exp_act;
        hold = int'($urandom_range(0, 6));
        exp_act = any_open();
        got = -1;
        r_pd = 1'b1;
        step(NOP, 2'd0);
        chk("R5 random entry", int'(cke), 0);
        for (int k = 1; k < 20; k++) begin
          if (k == hold + 1) r_pd = 1'b0;
          step(ACT, 2'd0);
          if (cke) begin
            got = k;
            break;
          end
          chk("R5 random flavour", int'(pdact), int'(exp_act));
        end
        r_pd = 1'b0;
        chk("R6 random exit cycle", got, exp_pd_len(hold));
        pd_exit_tail();
      end
    end
    step(PREA, 2'd0);
    model_cmd(PREA, 2'd0);

    // R5 precharge flavour
    r_pd = 1'b1;
    step(NOP, 2'd0);
    r_pd = 1'b0;
    step(NOP, 2'd0);
    chk("R5 precharge flavour", int'(pdact), 0);
    for (int k = 2; k < CKE; k++) step(NOP, 2'd0);
    step(NOP, 2'd0);
    chk("R6 exit precharge pd", int'(cke), 1);
    pd_exit_tail();

    // R7 deep power-down, R10 priority over power-down
    step(ACT, 2'd0);
    r_dpd = 1'b1;
    step(NOP, 2'd0);
    chk("R7 held with bank open", int'(cke), 1);
    step(PRE, 2'd0);
    r_busy = 1'b1;
    step(NOP, 2'd0);
    chk("R7 held with busy bus", int'(cke), 1);
    r_busy = 1'b0; r_pd = 1'b1;
    step(NOP, 2'd0);
    chk("R10 deep wins over pd", int'(cmd), int'(BST));
    chk("R7 entry cke", int'(cke), 0);
    r_pd = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(ACT, 2'd0);
      chk("R7 stays down", int'(cke), 0);
      chk("R9 blocked in deep", int'(cmd), int'(NOP));
    end
    r_dpd = 1'b0;
    step(NOP, 2'd0);
    chk("R7 exit cke", int'(cke), 1);
    step(PREA, 2'd0);
    chk("R7 reinit set", int'(reinit), 1);
    chk("R7 init commands forwarded", int'(cmd), int'(PREA));
    r_sr = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(NOP, 2'd0);
      chk("R7 request ignored", int'(cke), 1);
      chk("R7 reinit held", int'(reinit), 1);
    end
    r_sr = 1'b0; r_init = 1'b1;
    step(MRS, 2'd0);
    chk("R7 reinit until done", int'(reinit), 1);
    r_init = 1'b0;
    step(NOP, 2'd0);
    chk("R7 reinit cleared", int'(reinit), 0);
    chk("R1 after reinit", int'(ok), 1);

    // R8 status read, R10 priority over power-down
    r_srr = 1'b1; r_pd = 1'b1;
    step(ACT, 2'd2);
    chk("R10 status read wins over pd", int'(cmd), int'(MRS));
    chk("R8 mrs bank code", int'(ba), 1);
    chk("R8 mrs cke", int'(cke), 1);
    r_pd = 1'b0;
    srr_tail();

    // R10 self-refresh over power-down
    r_sr = 1'b1; r_pd = 1'b1;
    step(NOP, 2'd0);
    chk("R10 self-refresh wins over pd", int'(cmd), int'(REF));
    r_sr = 1'b0; r_pd = 1'b0;
    for (int k = 1; k < RFC; k++) step(NOP, 2'd0);
    step(NOP, 2'd0);
    chk("R3 exit after priority entry", int'(cke), 1);
    sr_exit_tail();

    // R8 held while a bank is open
    step(ACT, 2'd3);
    r_srr = 1'b1;
    step(NOP, 2'd0);
    chk("R8 held with bank open", int'(cmd), int'(NOP));
    chk("R8 held traffic ok", int'(ok), 1);
    step(PRE, 2'd3);
    step(NOP, 2'd0);
    chk("R8 entry after close", int'(cmd), int'(MRS));
    srr_tail();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule